// File: doc/BRIEF.md
# Write-Only I2C Voltage-Code Slave

This block sets the output-voltage code of a step-down regulator from a two-wire serial bus. It samples the bus clock and data lines on its own system clock and finds the bus start and stop markers. It then decodes one address byte followed by one data byte. When the address matches a fixed 7-bit value and the direction bit requests a write, the block acknowledges both bytes by pulling the data line low. It then loads the low five bits of the data byte into its code register.

Code 0 selects 0.60 V, and each step adds 50 mV. Written values above 28 are stored as 28, the 2.00 V ceiling. The register comes out of reset at 24 (1.80 V). A separate disable input returns it to 24 and holds the bus logic idle. Read transfers are never acknowledged. The system clock must run at least eight times faster than the bus clock.

Top module: `vcode_i2c_slave`

## Requirements
- R1: A transfer begins only with a START (data falls while the bus clock is high). Bytes clocked without a START are not acknowledged. A STOP (data rises while the bus clock is high) ends the transfer, and an unfinished byte is dropped without changing the code.
- R2: An address byte equal to 7'h14 followed by a direction bit of 0 (byte value 8'h28, MSB first) is acknowledged: `sda_pull_o` is high, so the data line reads 0, while the bus clock is high on the ninth clock.
- R3: Any other address, or a direction bit of 1, gets no acknowledge. No later byte of that transfer is acknowledged, and the code is left unchanged until the next START.
- R4: After an acknowledged address, the next byte (sampled MSB first on rising bus-clock edges) is acknowledged on its ninth clock. Once that clock falls, `code_o` takes data bits [4:0].
- R5: Data bits [7:5] have no effect. A bits [4:0] value above 28 (5'b11100) loads 28.
- R6: `code_o` changes only when a data acknowledge completes or when the block is disabled. A repeated START in the middle of a byte abandons the transfer with no update.
- R7: After reset, and one cycle after `disable_i` is sampled high, `code_o` is 24 (5'b11000). While `disable_i` is high, no byte is acknowledged and `sda_pull_o` stays low.
- R8: Only one data byte is taken per transfer. A second data byte is not acknowledged and does not alter the code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the bus clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as received |
| sda_i | input | 1 | Bus data line as received (includes this block's own pull) |
| disable_i | input | 1 | High forces the code to its default and the bus logic idle |
| sda_pull_o | output | 1 | High requests the open-drain data line be pulled low |
| code_o | output | 5 | Stored output-voltage code, 0 to 28 |

## Verification
The bench builds the block with its defaults: address 7'h14, a 5-bit code with ceiling 28 and default 24, and two synchroniser stages. Each bus-clock half period lasts 20 system clocks. This leaves room for the three-cycle synchroniser delay to settle before every acknowledge sample and every data change. It also makes the repeated START in the middle of a byte, the unaddressed bytes and the clamp boundary at 27, 28 and 31 cleanly observable at the ports.

// File: rtl/vcode_i2c_slave.sv
module vcode_i2c_slave #(
  parameter logic [6:0] DEV_ADDR = 7'h14,
  parameter int CODE_W = 5,
  parameter int CODE_MAX = 28,
  parameter int CODE_DEF = 24,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              disable_i,
  output logic              sda_pull_o,
  output logic [CODE_W-1:0] code_o
);

  localparam int BYTE_W = 8;
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);
  localparam logic [CODE_W-1:0] TOP = CODE_W'(CODE_MAX);
  localparam logic [CODE_W-1:0] DEF = CODE_W'(CODE_DEF);
  localparam logic [BYTE_W-1:0] WR_ADDR = {DEV_ADDR, 1'b0};

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_AACK, S_DATA, S_DACK, S_SKIP} state_t;

  logic [SYNC_N:0] scl_p, sda_p;
  logic scl_s, scl_q, sda_s, sda_q;
  logic start_det, stop_det, scl_rise, scl_fall;
  state_t state;
  logic [CNT_W-1:0] cnt;
  logic [BYTE_W-1:0] sh;
  logic [CODE_W-1:0] clamped;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= '1;
      sda_p <= '1;
    end else begin
      scl_p <= {scl_p[SYNC_N-1:0], scl_i};
      sda_p <= {sda_p[SYNC_N-1:0], sda_i};
    end
  end

  assign scl_s = scl_p[SYNC_N-1];
  assign scl_q = scl_p[SYNC_N];
  assign sda_s = sda_p[SYNC_N-1];
  assign sda_q = sda_p[SYNC_N];

  assign start_det = scl_s && scl_q && sda_q && !sda_s;
  assign stop_det  = scl_s && scl_q && !sda_q && sda_s;
  assign scl_rise  = scl_s && !scl_q;
  assign scl_fall  = !scl_s && scl_q;

  assign clamped = (sh[CODE_W-1:0] > TOP) ? TOP : sh[CODE_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      cnt        <= '0;
      sh         <= '0;
      sda_pull_o <= 1'b0;
      code_o     <= DEF;
    end else if (disable_i) begin
      state      <= S_IDLE;
      cnt        <= '0;
      sda_pull_o <= 1'b0;
      code_o     <= DEF;
    end else if (stop_det) begin
      state      <= S_IDLE;
      sda_pull_o <= 1'b0;
    end else if (start_det) begin
      state      <= S_ADDR;
      cnt        <= '0;
      sda_pull_o <= 1'b0;
    end else begin
      case (state)
        S_ADDR, S_DATA: begin
          if (scl_rise && cnt != FULL) begin
            sh  <= {sh[BYTE_W-2:0], sda_s};
            cnt <= cnt + 1'b1;
          end else if (scl_fall && cnt == FULL) begin
            if (state == S_DATA) begin
              state      <= S_DACK;
              sda_pull_o <= 1'b1;
            end else if (sh == WR_ADDR) begin
              state      <= S_AACK;
              sda_pull_o <= 1'b1;
            end else begin
              state <= S_SKIP;
            end
          end
        end
        S_AACK: begin
          if (scl_fall) begin
            sda_pull_o <= 1'b0;
            cnt        <= '0;
            state      <= S_DATA;
          end
        end
        S_DACK: begin
          if (scl_fall) begin
            sda_pull_o <= 1'b0;
            code_o     <= clamped;
            state      <= S_SKIP;
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/vcode_i2c_slave_chk.sv
module vcode_i2c_slave_chk #(
  parameter int CODE_W = 5,
  parameter int CODE_MAX = 28,
  parameter int CODE_DEF = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              disable_i,
  input logic              sda_pull_o,
  input logic [CODE_W-1:0] code_o
);

  localparam logic [CODE_W-1:0] TOP = CODE_W'(CODE_MAX);
  localparam logic [CODE_W-1:0] DEF = CODE_W'(CODE_DEF);

  AST_CODE_CEILING: assert property (@(posedge clk) disable iff (!rst_n) code_o <= TOP); // R5
  AST_CODE_CHANGE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(code_o) |-> ($past(disable_i) || $past(sda_pull_o))); // R6
  AST_DISABLE_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
    disable_i |=> code_o == DEF); // R7
  AST_DISABLE_NO_PULL: assert property (@(posedge clk) disable iff (!rst_n)
    disable_i |=> !sda_pull_o); // R7
  AST_RESET_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> code_o == DEF); // R7

endmodule

bind vcode_i2c_slave vcode_i2c_slave_chk #(
  .CODE_W(CODE_W), .CODE_MAX(CODE_MAX), .CODE_DEF(CODE_DEF)
) u_chk (
  .clk(clk), .rst_n(rst_n), .disable_i(disable_i),
  .sda_pull_o(sda_pull_o), .code_o(code_o)
);

// File: tb/vcode_i2c_slave_test.sv
module vcode_i2c_slave_test;
  localparam int H = 20;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, scl_m, sda_m, dis, pull;
  logic [4:0] code;
  wire sda_line = sda_m & ~pull;

  vcode_i2c_slave uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .disable_i(dis), .sda_pull_o(pull), .code_o(code)
  );

  typedef struct {bit is_code; int val; string req;} item_t;
  item_t q[$];
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push(bit is_code, int val, string req);
    item_t it;
    it.is_code = is_code;
    it.val = val;
    it.req = req;
    q.push_back(it);
  endtask

  initial begin
    item_t it;
    int act;
    forever begin
      wait (q.size() != 0);
      it = q.pop_front();
      act = it.is_code ? int'(code) : int'(sda_line);
      n_chk++;
      if (act != it.val) begin
        n_fail++;
        $display("FAIL %s (%s): got %0d expected %0d", it.req,
                 it.is_code ? "code" : "ack line", act, it.val);
      end
    end
  end

  task automatic bus_start();
    sda_m = 1'b1; scl_m = 1'b1; tick(H);
    sda_m = 1'b0; tick(H);
    scl_m = 1'b0; tick(H);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(H);
    scl_m = 1'b1; tick(H);
    sda_m = 1'b1; tick(H);
  endtask

  task automatic send_bits(logic [7:0] b, int n);
    for (int i = 0; i < n; i++) begin
      sda_m = b[7-i]; tick(H);
      scl_m = 1'b1; tick(H);
      scl_m = 1'b0;
    end
  endtask

  task automatic send_byte(logic [7:0] b, bit ack, string req);
    send_bits(b, 8);
    sda_m = 1'b1; tick(H);
    scl_m = 1'b1; tick(H/2);
    push(1'b0, ack ? 0 : 1, req);
    tick(H/2);
    scl_m = 1'b0; tick(H);
  endtask

  task automatic write_xfer(logic [7:0] a, bit aack, logic [7:0] d, bit dack, string req);
    bus_start();
    send_byte(a, aack, req);
    send_byte(d, dack, req);
    bus_stop();
    tick(5);
  endtask

  initial begin
    rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1; dis = 1'b0;
    tick(5);
    rst_n = 1'b1;
    tick(5);
    push(1'b1, 24, "R7 reset default");

    write_xfer(8'h28, 1, 8'h0A, 1, "R2 R4 basic write");
    push(1'b1, 10, "R4 code loaded");
    write_xfer(8'h28, 1, 8'hE3, 1, "R5 upper bits");
    push(1'b1, 3, "R5 upper bits ignored");
    write_xfer(8'h28, 1, 8'h1F, 1, "R5 clamp 31");
    push(1'b1, 28, "R5 clamp 31");
    write_xfer(8'h28, 1, 8'h1B, 1, "R5 below ceiling");
    push(1'b1, 27, "R5 value 27");
    write_xfer(8'h28, 1, 8'h1C, 1, "R5 ceiling");
    push(1'b1, 28, "R5 value 28");
    write_xfer(8'h28, 1, 8'h00, 1, "R4 zero");
    push(1'b1, 0, "R4 zero code");

    write_xfer(8'h2A, 0, 8'h28, 0, "R3 wrong address");
    push(1'b1, 0, "R3 wrong address code held");
    write_xfer(8'h29, 0, 8'h05, 0, "R3 read direction");
    push(1'b1, 0, "R3 read code held");

    scl_m = 1'b0; tick(H);
    send_byte(8'h28, 0, "R1 no start");
    send_byte(8'h05, 0, "R1 no start");
    bus_stop(); tick(5);
    push(1'b1, 0, "R1 no start code held");

    bus_start();
    send_byte(8'h28, 1, "R1 stop mid byte");
    send_bits(8'h0F, 3);
    bus_stop(); tick(5);
    push(1'b1, 0, "R1 stop mid byte code held");

    bus_start();
    send_byte(8'h28, 1, "R8 two bytes");
    send_byte(8'h07, 1, "R8 first byte");
    send_byte(8'h11, 0, "R8 second byte");
    bus_stop(); tick(5);
    push(1'b1, 7, "R8 second byte ignored");

    bus_start();
    send_byte(8'h28, 1, "R6 restart");
    send_bits(8'h14, 4);
    sda_m = 1'b1; tick(H);
    scl_m = 1'b1; tick(H);
    sda_m = 1'b0; tick(H);
    scl_m = 1'b0; tick(H);
    push(1'b1, 7, "R6 restart no update");
    send_byte(8'h28, 1, "R6 after restart");
    send_byte(8'h12, 1, "R6 after restart");
    bus_stop(); tick(5);
    push(1'b1, 18, "R6 write after restart");

    dis = 1'b1; tick(3);
    push(1'b1, 24, "R7 disable default");
    write_xfer(8'h28, 0, 8'h03, 0, "R7 disabled bus");
    push(1'b1, 24, "R7 disabled code held");
    dis = 1'b0; tick(3);
    write_xfer(8'h28, 1, 8'h09, 1, "R7 re-enabled");
    push(1'b1, 9, "R7 re-enabled write");

    tick(10);
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule